// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. Conditional branches in this pipeline are resolved in decode by a dedicated register-equality comparator. The block takes register numbers and control flags from the three pipeline latches and from decode. From these it chooses where each execute-stage ALU operand comes from, and where each comparator operand comes from. The choice is between the register-file read, the memory-stage result and the writeback-stage result. When the younger producer and the older one both hold a needed register, the younger one wins.

Some dependencies cannot be covered by forwarding, and for these the block holds the PC and the IF/ID latch and inserts a no-op bubble into ID/EX. This happens when a load in execute feeds the instruction in decode. It also happens when a branch in decode needs an ALU or load result that is still in execute, or a load result that is still in the memory stage. A branch that depends on a load therefore waits two cycles. When a branch in decode is taken and nothing holds it back, the block clears IF/ID so that the wrongly fetched instruction is dropped.

The block is purely combinational. Every output is a function of the current inputs. There is no data stream, so every pin is a plain control signal with no valid/ready handshake.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each ALU operand select (`alu_sel_a` for `exe_rs`, `alu_sel_b` for `exe_rt`) is 2'b10 when the memory-stage producer matches, otherwise 2'b01 when the writeback-stage producer matches, otherwise 2'b00 (register file). A match means the write flag is set, the destination is nonzero and the destination equals the source.
- R2: When the memory-stage and writeback-stage producers both match a source, the select is 2'b10.
- R3: Register 0 is never forwarded. A producer whose write flag is clear is never forwarded, whatever its destination.
- R4: The comparator selects `cmp_sel_a` (for `dec_rs`) and `cmp_sel_b` (for `dec_rt`) use the same encoding and priority as R1. The one exception is a memory-stage producer with `mem_load` set, which is never chosen (2'b10 never appears).
- R5: A load in execute (`exe_load`) with nonzero `exe_rd` equal to `dec_rs` or `dec_rt` causes a stall.
- R6: A branch in decode (`dec_branch`) stalls when the execute-stage producer has `exe_wr` set, nonzero `exe_rd`, and `exe_rd` equal to `dec_rs` or `dec_rt`.
- R7: A branch in decode stalls when a memory-stage load (`mem_load` and `mem_wr`) has nonzero `mem_rd` equal to `dec_rs` or `dec_rt`.
- R8: During a stall, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1. With no stall condition they are all 0, and this includes all-zero inputs.
- R9: `ifid_flush` is 1 exactly when `dec_branch` and `dec_take` are 1 and there is no stall.
- R10: A branch that depends on a load stalls while the load is in execute and again while it is in memory. Once the load reaches writeback, the stall ends and the comparator select is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | AW | First source register of the instruction in decode |
| dec_rt | input | AW | Second source register of the instruction in decode |
| dec_branch | input | 1 | Instruction in decode is a conditional branch |
| dec_take | input | 1 | Comparator outcome: branch taken |
| exe_rs | input | AW | First source register in ID/EX |
| exe_rt | input | AW | Second source register in ID/EX |
| exe_rd | input | AW | Destination register in ID/EX |
| exe_wr | input | 1 | ID/EX instruction writes a register |
| exe_load | input | 1 | ID/EX instruction is a load |
| mem_rd | input | AW | Destination register in EX/MEM |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| wb_rd | input | AW | Destination register in MEM/WB |
| wb_wr | input | 1 | MEM/WB instruction writes a register |
| alu_sel_a | output | 2 | Source select for ALU operand A |
| alu_sel_b | output | 2 | Source select for ALU operand B |
| cmp_sel_a | output | 2 | Source select for comparator operand A |
| cmp_sel_b | output | 2 | Source select for comparator operand B |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep IF/ID unchanged |
| idex_bubble | output | 1 | Load all-zero control into ID/EX |
| ifid_flush | output | 1 | Clear IF/ID after a taken branch |

## Verification
The assertions assume only that the inputs are settled values. They do not rely on a load flag implying a write flag, so they hold for any combination the latches could present, including ones a real pipeline never produces. The random stimulus draws register numbers from a four-value range that includes register 0, so that matches, double matches and zero destinations are frequent. All flags are drawn independently, which also produces unreachable mixes such as a load without a write flag. The two-cycle load-to-branch case is driven as a directed sequence that moves the load one stage per cycle, in the way a pipeline honouring the stall would.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
// Chooses an operand source for one register read: the younger (memory
// stage) producer first, then the older (writeback stage) one.
module fwd_pick #(
  parameter int AW             = 5,
  parameter bit SKIP_NEAR_LOAD = 1'b0
) (
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    near_rd,
  input  logic             near_wr,
  input  logic             near_load,
  input  logic [AW-1:0]    far_rd,
  input  logic             far_wr,
  output hz_pkg::fwd_sel_e sel
);
  localparam logic [AW-1:0] ZERO = '0;

  logic near_ok;
  logic near_hit;
  logic far_hit;

  generate
    if (SKIP_NEAR_LOAD) begin : g_gate
      // load data is not ready yet in this stage; decode must wait instead
      assign near_ok = near_wr & ~near_load;
      always_comb begin
        p_no_load_to_cmp_r4: assert (!(near_load && sel == hz_pkg::SEL_MEM))
          else $error("load result forwarded from memory stage");
      end
    end else begin : g_pass
      logic unused_load;
      assign near_ok     = near_wr;
      assign unused_load = near_load;
    end
  endgenerate

  assign near_hit = near_ok && (near_rd != ZERO) && (near_rd == src);
  assign far_hit  = far_wr  && (far_rd  != ZERO) && (far_rd  == src);

  always_comb begin
    if (near_hit)     sel = hz_pkg::SEL_MEM;
    else if (far_hit) sel = hz_pkg::SEL_WB;
    else              sel = hz_pkg::SEL_RF;
  end

  always_comb begin
    p_r0_never_fwd_r3: assert (src != ZERO || sel == hz_pkg::SEL_RF)
      else $error("register zero forwarded");
    p_wr_needed_r3: assert (sel != hz_pkg::SEL_WB || far_wr)
      else $error("writeback forward without write flag");
  end
endmodule

// File: rtl/hazard_detect.sv
// Finds dependencies that forwarding cannot cover.
module hazard_detect #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_branch,
  input  logic [AW-1:0] exe_rd,
  input  logic          exe_wr,
  input  logic          exe_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  output logic          stall
);
  localparam logic [AW-1:0] ZERO = '0;

  logic exe_feeds_dec;
  logic mem_feeds_dec;
  logic load_use;
  logic br_on_exe;
  logic br_on_mem_load;

  assign exe_feeds_dec  = (exe_rd != ZERO) && (exe_rd == dec_rs || exe_rd == dec_rt);
  assign mem_feeds_dec  = (mem_rd != ZERO) && (mem_rd == dec_rs || mem_rd == dec_rt);

  assign load_use       = exe_load & exe_feeds_dec;
  assign br_on_exe      = dec_branch & exe_wr & exe_feeds_dec;
  assign br_on_mem_load = dec_branch & mem_load & mem_wr & mem_feeds_dec;

  assign stall = load_use | br_on_exe | br_on_mem_load;

  always_comb begin
    p_nobranch_mem_r7: assert (dec_branch || !br_on_mem_load)
      else $error("branch hazard flagged without branch");
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_branch,
  input  logic          dec_take,
  input  logic [AW-1:0] exe_rs,
  input  logic [AW-1:0] exe_rt,
  input  logic [AW-1:0] exe_rd,
  input  logic          exe_wr,
  input  logic          exe_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic [1:0]    alu_sel_a,
  output logic [1:0]    alu_sel_b,
  output logic [1:0]    cmp_sel_a,
  output logic [1:0]    cmp_sel_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  localparam int NALU  = 2;
  localparam int NPICK = 2 * NALU;
  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0]    pick_src [NPICK];
  hz_pkg::fwd_sel_e pick_sel [NPICK];
  logic             stall;

  // first half feeds the ALU, second half the decode comparator
  assign pick_src[0] = exe_rs;
  assign pick_src[1] = exe_rt;
  assign pick_src[2] = dec_rs;
  assign pick_src[3] = dec_rt;

  generate
    for (genvar g = 0; g < NPICK; g++) begin : g_pick
      fwd_pick #(
        .AW             (AW),
        .SKIP_NEAR_LOAD (g >= NALU)
      ) u_pick (
        .src       (pick_src[g]),
        .near_rd   (mem_rd),
        .near_wr   (mem_wr),
        .near_load (mem_load),
        .far_rd    (wb_rd),
        .far_wr    (wb_wr),
        .sel       (pick_sel[g])
      );
    end
  endgenerate

  hazard_detect #(.AW(AW)) u_haz (
    .dec_rs     (dec_rs),
    .dec_rt     (dec_rt),
    .dec_branch (dec_branch),
    .exe_rd     (exe_rd),
    .exe_wr     (exe_wr),
    .exe_load   (exe_load),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_load   (mem_load),
    .stall      (stall)
  );

  assign alu_sel_a   = pick_sel[0];
  assign alu_sel_b   = pick_sel[1];
  assign cmp_sel_a   = pick_sel[2];
  assign cmp_sel_b   = pick_sel[3];

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  // a held branch re-resolves next cycle, so no flush yet
  assign ifid_flush  = dec_branch & dec_take & ~stall;

  always_comb begin
    p_flush_not_held_r9: assert (!(ifid_flush && pc_hold))
      else $error("flush during stall");
    p_hold_together_r8: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
      else $error("stall controls disagree");
    p_branch_exe_dep_r6: assert (!(dec_branch && exe_wr && exe_rd != ZERO &&
                                   exe_rd == dec_rs) || pc_hold)
      else $error("branch on execute result not held");
    p_load_use_r5: assert (!(exe_load && exe_rd != ZERO && exe_rd == dec_rt) || idex_bubble)
      else $error("load-use without bubble");
  end
endmodule

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] dec_rs, dec_rt, exe_rs, exe_rt, exe_rd, mem_rd, wb_rd;
  logic dec_branch, dec_take, exe_wr, exe_load, mem_wr, mem_load, wb_wr;
  logic [1:0] alu_sel_a, alu_sel_b, cmp_sel_a, cmp_sel_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int n_chk = 0;
  int n_bad = 0;

  hazard_fwd_unit #(.AW(AW)) u0 (
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_branch(dec_branch), .dec_take(dec_take),
    .exe_rs(exe_rs), .exe_rt(exe_rt), .exe_rd(exe_rd), .exe_wr(exe_wr),
    .exe_load(exe_load), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_wr(wb_wr),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .cmp_sel_a(cmp_sel_a),
    .cmp_sel_b(cmp_sel_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_alu(input logic [AW-1:0] s);
    if (mem_wr && mem_rd != 0 && mem_rd == s) return 2;
    if (wb_wr && wb_rd != 0 && wb_rd == s) return 1;
    return 0;
  endfunction

  function automatic int exp_cmp(input logic [AW-1:0] s);
    if (mem_wr && !mem_load && mem_rd != 0 && mem_rd == s) return 2;
    if (wb_wr && wb_rd != 0 && wb_rd == s) return 1;
    return 0;
  endfunction

  function automatic int exp_stall();
    bit ehit, mhit;
    ehit = exe_rd != 0 && (exe_rd == dec_rs || exe_rd == dec_rt);
    mhit = mem_rd != 0 && (mem_rd == dec_rs || mem_rd == dec_rt);
    return int'((exe_load && ehit) || (dec_branch && exe_wr && ehit) ||
                (dec_branch && mem_load && mem_wr && mhit));
  endfunction

  task automatic clear_all();
    dec_rs = 0; dec_rt = 0; dec_branch = 0; dec_take = 0;
    exe_rs = 0; exe_rt = 0; exe_rd = 0; exe_wr = 0; exe_load = 0;
    mem_rd = 0; mem_wr = 0; mem_load = 0; wb_rd = 0; wb_wr = 0;
  endtask

  // inputs are set right after a falling edge; outputs sampled 2 ns later
  task automatic check_all(input string tag);
    int st;
    #2;
    st = exp_stall();
    chk({tag, "/R1"}, "alu_sel_a", int'(alu_sel_a), exp_alu(exe_rs));
    chk({tag, "/R1"}, "alu_sel_b", int'(alu_sel_b), exp_alu(exe_rt));
    chk({tag, "/R4"}, "cmp_sel_a", int'(cmp_sel_a), exp_cmp(dec_rs));
    chk({tag, "/R4"}, "cmp_sel_b", int'(cmp_sel_b), exp_cmp(dec_rt));
    chk({tag, "/R8"}, "pc_hold", int'(pc_hold), st);
    chk({tag, "/R8"}, "ifid_hold", int'(ifid_hold), st);
    chk({tag, "/R8"}, "idex_bubble", int'(idex_bubble), st);
    chk({tag, "/R9"}, "ifid_flush", int'(ifid_flush), int'(dec_branch && dec_take && st == 0));
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    clear_all();
    @(negedge clk);
    // idle: no selects, no stall (R8)
    check_all("R8 idle");
    chk("R8", "idle pc_hold", int'(pc_hold), 0);
    chk("R1", "idle alu_sel_a", int'(alu_sel_a), 0);

    // R2: both producers match, younger wins
    @(negedge clk); clear_all();
    exe_rs = 3; mem_rd = 3; mem_wr = 1; wb_rd = 3; wb_wr = 1;
    check_all("R2");
    chk("R2", "alu_sel_a both match", int'(alu_sel_a), 2);

    // R3: register zero and cleared write flag
    @(negedge clk); clear_all();
    exe_rs = 0; mem_rd = 0; mem_wr = 1; wb_rd = 0; wb_wr = 1;
    exe_rt = 6; wb_rd = 0;
    check_all("R3");
    chk("R3", "r0 not forwarded", int'(alu_sel_a), 0);
    @(negedge clk); clear_all();
    exe_rt = 6; mem_rd = 6; mem_wr = 0; wb_rd = 6; wb_wr = 0;
    check_all("R3");
    chk("R3", "write flag clear", int'(alu_sel_b), 0);

    // R4: load in memory stage is not forwarded to comparator
    @(negedge clk); clear_all();
    dec_rs = 2; mem_rd = 2; mem_wr = 1; mem_load = 1; wb_rd = 2; wb_wr = 1;
    check_all("R4");
    chk("R4", "cmp skips mem load", int'(cmp_sel_a), 1);

    // R5: load-use
    @(negedge clk); clear_all();
    dec_rt = 4; exe_rd = 4; exe_wr = 1; exe_load = 1;
    check_all("R5");
    chk("R5", "load-use stall", int'(idex_bubble), 1);

    // R6: branch on ALU result in execute, taken but held
    @(negedge clk); clear_all();
    dec_branch = 1; dec_take = 1; dec_rs = 5; exe_rd = 5; exe_wr = 1;
    check_all("R6");
    chk("R6", "branch exe stall", int'(pc_hold), 1);
    chk("R9", "no flush while held", int'(ifid_flush), 0);

    // R7: branch on load in memory stage
    @(negedge clk); clear_all();
    dec_branch = 1; dec_rt = 6; mem_rd = 6; mem_wr = 1; mem_load = 1;
    check_all("R7");
    chk("R7", "branch mem load stall", int'(ifid_hold), 1);

    // R9: taken branch with no hazard flushes; take without branch does not
    @(negedge clk); clear_all();
    dec_branch = 1; dec_take = 1; dec_rs = 1; dec_rt = 2;
    check_all("R9");
    chk("R9", "taken flush", int'(ifid_flush), 1);
    @(negedge clk); clear_all();
    dec_take = 1;
    check_all("R9");
    chk("R9", "take without branch", int'(ifid_flush), 0);

    // R10: load-to-branch dependency across three cycles
    @(negedge clk); clear_all();
    dec_branch = 1; dec_rs = 7; exe_rd = 7; exe_wr = 1; exe_load = 1;
    check_all("R10");
    chk("R10", "cycle1 stall", int'(pc_hold), 1);
    @(negedge clk);
    exe_rd = 0; exe_wr = 0; exe_load = 0; mem_rd = 7; mem_wr = 1; mem_load = 1;
    check_all("R10");
    chk("R10", "cycle2 stall", int'(pc_hold), 1);
    @(negedge clk);
    mem_rd = 0; mem_wr = 0; mem_load = 0; wb_rd = 7; wb_wr = 1;
    check_all("R10");
    chk("R10", "cycle3 released", int'(pc_hold), 0);
    chk("R10", "cycle3 cmp from wb", int'(cmp_sel_a), 1);

    // random mix over a small register range
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      dec_rs = AW'($urandom_range(3)); dec_rt = AW'($urandom_range(3));
      exe_rs = AW'($urandom_range(3)); exe_rt = AW'($urandom_range(3));
      exe_rd = AW'($urandom_range(3)); mem_rd = AW'($urandom_range(3));
      wb_rd  = AW'($urandom_range(3));
      dec_branch = 1'($urandom); dec_take = 1'($urandom);
      exe_wr = 1'($urandom); exe_load = 1'($urandom);
      mem_wr = 1'($urandom); mem_load = 1'($urandom); wb_wr = 1'($urandom);
      check_all("rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule